// File: doc/BRIEF.md
# Block-Transfer Host Mailbox (controller side)

This block sits between a host bus and a management controller and moves whole messages between them. The host sees three byte-wide registers. A control register carries the handshake flags. A buffer port streams bytes into the request store or out of the response store. An interrupt register holds an enable bit and a pending bit. The request and response stores each have their own pointer, and that pointer advances by one on every buffer access.

A host transaction runs in this order:

1. The host clears the write pointer.
2. It writes a length byte, then the network-function byte, a sequence byte, the command and any data. The length byte counts only the bytes that follow it.
3. It sets host-to-controller attention.

The block then moves the request to the controller. It sets its own busy flag and drops the attention flag. It also gives one pulse on `req_valid` with the captured length byte. The controller reads the request through a random-access port and releases busy when it is done.

Responses go the other way. The controller loads the response through a write port in the same layout and then posts it. Posting raises controller-to-host attention, and the rising edge of that flag latches an interrupt. The host then:

1. Toggles its busy flag.
2. Clears attention.
3. Rewinds the read pointer.
4. Reads the response bytes.

Command decoding is outside this block.

Top module: `bt_host_if`

## Requirements
- R1: After reset, the control register (offset 0) reads 0x00, the interrupt register (offset 2) reads 0x00, and `host_irq` and `req_valid` are low.
- R2: A host write to offset 1 stores the byte at the write pointer, and the pointer then advances by one. Writing 0x01 to control (bit 0) returns the write pointer to 0. The byte stored at index 0 appears on `req_len`.
- R3: A host read of offset 1 returns the response byte at the read pointer, and the pointer then advances by one. Writing 0x02 to control (bit 1) returns the read pointer to 0.
- R4: Writing 0x04 to control sets host-to-controller attention (bit 2). The block checks for a waiting request on every clock edge. On the first edge where attention is set and controller-busy (bit 7) is clear, it clears attention and sets controller-busy. `req_valid` is high for exactly the following cycle.
- R5: While controller-busy is set, a host attention request stays pending in bit 2 and is not taken. A `req_done` pulse clears busy, and the pending request is taken on the next edge.
- R6: A `rsp_post` pulse sets controller-to-host attention (bit 3). A host write of 0x08 to control clears it.
- R7: A `sms_set` pulse sets the event-attention flag (bit 4). A host write of 0x10 to control clears it.
- R8: Each host write of 0x40 to control toggles host-busy (bit 6).
- R9: In the interrupt register, bit 0 is the enable and bit 1 is pending. Pending is set only on a 0-to-1 change of bit 3, and `host_irq` equals enable AND pending. Writing the register loads the enable from bit 0 and clears pending when bit 1 is 1, so 0x03 acknowledges while keeping the interrupt enabled.
- R10: Both buffer pointers wrap from DEPTH-1 to 0.
- R11: Host writes to control bits 5 and 7 have no effect. Controller-busy rises only when a pending attention request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Host register select: 0 control, 1 buffer, 2 interrupt |
| host_wr | input | 1 | Host write strobe, one per clock |
| host_rd | input | 1 | Host read strobe; reading the buffer advances the read pointer |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register contents |
| host_irq | output | 1 | Interrupt to the host |
| req_valid | output | 1 | One-cycle pulse when a request is handed over |
| req_len | output | 8 | Request byte stored at index 0 |
| req_rd_addr | input | log2(DEPTH) | Controller read index into the request store |
| req_rd_data | output | 8 | Request byte at `req_rd_addr` |
| req_done | input | 1 | Controller finished with the request; clears busy |
| rsp_we | input | 1 | Response store write enable |
| rsp_addr | input | log2(DEPTH) | Response store write index |
| rsp_wdata | input | 8 | Response store write data |
| rsp_post | input | 1 | Raise controller-to-host attention |
| sms_set | input | 1 | Raise the event-attention flag |

## Verification
The bench builds the block with DEPTH = 8 rather than 64. With eight entries, a run of nine buffer accesses in each direction crosses both pointer wraps, so the wrap values can be checked directly. The response store is fully preloaded before the read-wrap test, so every byte that comes back has a known value. The smaller store also keeps the request, hand-over and response sequences short enough to check their timing cycle by cycle.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_BUF  = 2'd1;
  localparam logic [1:0] OFF_IRQ  = 2'd2;

  localparam int CB_CLR_WR = 0;
  localparam int CB_CLR_RD = 1;
  localparam int CB_H2B    = 2;
  localparam int CB_B2H    = 3;
  localparam int CB_EVT    = 4;
  localparam int CB_HBUSY  = 6;
  localparam int CB_BBUSY  = 7;

  localparam int IB_EN   = 0;
  localparam int IB_PEND = 1;
endpackage

// File: rtl/bt_ptr.sv
module bt_ptr #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     inc,
  output logic [$clog2(DEPTH)-1:0] ptr
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)
      ptr_d = '0;
    else if (inc)
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (clr || inc)
      ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R10
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && ptr_q == LAST) |=> (ptr_q == '0));
endmodule

// File: rtl/bt_msg_buf.sv
module bt_msg_buf #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bt_flags.sv
module bt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_h2b,
  input  logic wr_b2h,
  input  logic wr_evt,
  input  logic wr_hbusy,
  input  logic irq_wr,
  input  logic irq_en_val,
  input  logic irq_ack,
  input  logic rsp_post,
  input  logic sms_set,
  input  logic req_done,
  output logic h2b,
  output logic b2h,
  output logic evt,
  output logic hbusy,
  output logic bbusy,
  output logic irq_en,
  output logic irq_pend,
  output logic take
);
  logic h2b_q, b2h_q, evt_q, hbusy_q, bbusy_q, en_q, pend_q, take_q;
  logic h2b_d, b2h_d, evt_d, hbusy_d, bbusy_d, en_d, pend_d, take_d;

  always_comb begin
    h2b_d   = h2b_q;
    b2h_d   = b2h_q;
    evt_d   = evt_q;
    hbusy_d = hbusy_q;
    bbusy_d = bbusy_q;
    en_d    = en_q;
    pend_d  = pend_q;
    take_d  = h2b_q && !bbusy_q;

    if (req_done) bbusy_d = 1'b0;
    if (take_d) begin
      h2b_d   = 1'b0;
      bbusy_d = 1'b1;
    end
    if (wr_h2b)   h2b_d   = 1'b1;
    if (wr_b2h)   b2h_d   = 1'b0;
    if (wr_evt)   evt_d   = 1'b0;
    if (wr_hbusy) hbusy_d = !hbusy_q;
    if (sms_set)  evt_d   = 1'b1;
    if (rsp_post) b2h_d   = 1'b1;

    if (irq_wr) begin
      en_d = irq_en_val;
      if (irq_ack) pend_d = 1'b0;
    end
    if (rsp_post && !b2h_q) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2b_q   <= 1'b0;
      b2h_q   <= 1'b0;
      evt_q   <= 1'b0;
      hbusy_q <= 1'b0;
      bbusy_q <= 1'b0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      h2b_q   <= h2b_d;
      b2h_q   <= b2h_d;
      evt_q   <= evt_d;
      hbusy_q <= hbusy_d;
      bbusy_q <= bbusy_d;
      en_q    <= en_d;
      pend_q  <= pend_d;
      take_q  <= take_d;
    end
  end

  assign h2b      = h2b_q;
  assign b2h      = b2h_q;
  assign evt      = evt_q;
  assign hbusy    = hbusy_q;
  assign bbusy    = bbusy_q;
  assign irq_en   = en_q;
  assign irq_pend = pend_q;
  assign take     = take_q;

  // R4
  take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h2b_q && !bbusy_q) |=> (bbusy_q && take_q));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bbusy_q && !req_done) |=> bbusy_q);

  // R11
  bbusy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bbusy_q) |-> $past(h2b_q));

  // R9
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b2h_q) |-> pend_q);

  // R6
  b2h_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b2h && !rsp_post) |=> !b2h_q);
endmodule

// File: rtl/bt_host_if.sv
module bt_host_if #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               host_addr,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [7:0]               host_wdata,
  output logic [7:0]               host_rdata,
  output logic                     host_irq,
  output logic                     req_valid,
  output logic [7:0]               req_len,
  input  logic [$clog2(DEPTH)-1:0] req_rd_addr,
  output logic [7:0]               req_rd_data,
  input  logic                     req_done,
  input  logic                     rsp_we,
  input  logic [$clog2(DEPTH)-1:0] rsp_addr,
  input  logic [7:0]               rsp_wdata,
  input  logic                     rsp_post,
  input  logic                     sms_set
);
  import bt_pkg::*;

  localparam int AW = $clog2(DEPTH);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic ctrl_wr, buf_wr, buf_rd, irq_wr;
  assign ctrl_wr = host_wr && (host_addr == OFF_CTRL);
  assign buf_wr  = host_wr && (host_addr == OFF_BUF);
  assign buf_rd  = host_rd && (host_addr == OFF_BUF);
  assign irq_wr  = host_wr && (host_addr == OFF_IRQ);

  logic [AW-1:0] wptr, rptr;
  logic [7:0]    rsp_byte;

  bt_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(ctrl_wr && host_wdata[CB_CLR_WR]), .inc(buf_wr), .ptr(wptr));

  bt_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(ctrl_wr && host_wdata[CB_CLR_RD]), .inc(buf_rd), .ptr(rptr));

  bt_msg_buf #(.DEPTH(DEPTH), .W(8)) u_req_buf (
    .clk(clk), .we(buf_wr), .waddr(wptr), .wdata(host_wdata),
    .raddr(req_rd_addr), .rdata(req_rd_data));

  bt_msg_buf #(.DEPTH(DEPTH), .W(8)) u_rsp_buf (
    .clk(clk), .we(rsp_we), .waddr(rsp_addr), .wdata(rsp_wdata),
    .raddr(rptr), .rdata(rsp_byte));

  logic h2b, b2h, evt, hbusy, bbusy, irq_en, irq_pend, take;

  bt_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_h2b(ctrl_wr && host_wdata[CB_H2B]),
    .wr_b2h(ctrl_wr && host_wdata[CB_B2H]),
    .wr_evt(ctrl_wr && host_wdata[CB_EVT]),
    .wr_hbusy(ctrl_wr && host_wdata[CB_HBUSY]),
    .irq_wr(irq_wr),
    .irq_en_val(host_wdata[IB_EN]),
    .irq_ack(host_wdata[IB_PEND]),
    .rsp_post(rsp_post), .sms_set(sms_set), .req_done(req_done),
    .h2b(h2b), .b2h(b2h), .evt(evt), .hbusy(hbusy), .bbusy(bbusy),
    .irq_en(irq_en), .irq_pend(irq_pend), .take(take));

  logic [7:0] len_q, len_d;
  logic       len_load;

  assign len_load = buf_wr && (wptr == '0);

  always_comb begin
    len_d = len_q;
    if (len_load) len_d = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   len_q <= 8'h00;
    else if (len_load) len_q <= len_d;
  end

  logic [7:0] ctrl_view, irq_view;

  always_comb begin
    ctrl_view           = 8'h00;
    ctrl_view[CB_H2B]   = h2b;
    ctrl_view[CB_B2H]   = b2h;
    ctrl_view[CB_EVT]   = evt;
    ctrl_view[CB_HBUSY] = hbusy;
    ctrl_view[CB_BBUSY] = bbusy;
    irq_view            = 8'h00;
    irq_view[IB_EN]     = irq_en;
    irq_view[IB_PEND]   = irq_pend;
    case (host_addr)
      OFF_CTRL: host_rdata = ctrl_view;
      OFF_BUF:  host_rdata = rsp_byte;
      OFF_IRQ:  host_rdata = irq_view;
      default:  host_rdata = 8'h00;
    endcase
  end

  assign host_irq  = irq_en && irq_pend;
  assign req_valid = take;
  assign req_len   = len_q;

  // R2
  wptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buf_wr && !ctrl_wr && wptr != AW'(DEPTH - 1)) |=> (wptr == $past(wptr) + 1'b1));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!irq_en) |-> !host_irq);
endmodule

// File: tb/bt_host_if_test.sv
module bt_host_if_test;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    host_addr;
  logic          host_wr, host_rd;
  logic [7:0]    host_wdata, host_rdata;
  logic          host_irq, req_valid;
  logic [7:0]    req_len, req_rd_data;
  logic [AW-1:0] req_rd_addr, rsp_addr;
  logic          req_done, rsp_we, rsp_post, sms_set;
  logic [7:0]    rsp_wdata;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  bt_host_if #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .req_valid(req_valid), .req_len(req_len),
    .req_rd_addr(req_rd_addr), .req_rd_data(req_rd_data), .req_done(req_done),
    .rsp_we(rsp_we), .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata),
    .rsp_post(rsp_post), .sms_set(sms_set));

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic mrd(input logic [AW-1:0] a, output logic [7:0] d);
    req_rd_addr = a;
    #1 d = req_rd_data;
  endtask

  task automatic rsp_load(input logic [AW-1:0] a, input logic [7:0] d);
    rsp_addr = a; rsp_wdata = d; rsp_we = 1'b1;
    @(negedge clk);
    rsp_we = 1'b0;
  endtask

  task automatic pulse_done();
    req_done = 1'b1; @(negedge clk); req_done = 1'b0;
  endtask

  task automatic pulse_post();
    rsp_post = 1'b1; @(negedge clk); rsp_post = 1'b0;
  endtask

  task automatic pulse_sms();
    sms_set = 1'b1; @(negedge clk); sms_set = 1'b0;
  endtask

  // {write offset, write data, read offset, expected read}
  localparam logic [19:0] VEC [8] = '{
    {2'd0, 8'h40, 2'd0, 8'h40},   // R8 toggle on
    {2'd0, 8'h80, 2'd0, 8'h40},   // R11 bit 7 ignored
    {2'd0, 8'h20, 2'd0, 8'h40},   // R11 bit 5 ignored
    {2'd0, 8'h40, 2'd0, 8'h00},   // R8 toggle off
    {2'd2, 8'h01, 2'd2, 8'h01},   // R9 enable
    {2'd2, 8'h03, 2'd2, 8'h01},   // R9 ack keeps enable
    {2'd2, 8'h00, 2'd2, 8'h00},   // R9 disable
    {2'd0, 8'h08, 2'd0, 8'h00}    // R6 clear when already clear
  };
  localparam string VREQ [8] = '{"R8", "R11", "R11", "R8", "R9", "R9", "R9", "R6"};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; host_addr = 2'd0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = 8'h00; req_rd_addr = '0; req_done = 1'b0;
    rsp_we = 1'b0; rsp_addr = '0; rsp_wdata = 8'h00; rsp_post = 1'b0; sms_set = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    hr(2'd0, v); chk("R1", "ctrl after reset", v, 8'h00);
    hr(2'd2, v); chk("R1", "irq reg after reset", v, 8'h00);
    chk("R1", "host_irq", {7'd0, host_irq}, 8'h00);
    chk("R1", "req_valid", {7'd0, req_valid}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      hw(VEC[i][19:18], VEC[i][17:10]);
      hr(VEC[i][9:8], v);
      chk(VREQ[i], $sformatf("vector %0d", i), v, VEC[i][7:0]);
    end

    // R2 request loading
    hw(2'd0, 8'h01);
    hw(2'd1, 8'h03); hw(2'd1, 8'h18); hw(2'd1, 8'h05); hw(2'd1, 8'h01);
    mrd(3'd1, v); chk("R2", "req byte 1", v, 8'h18);
    mrd(3'd2, v); chk("R2", "req byte 2", v, 8'h05);
    mrd(3'd3, v); chk("R2", "req byte 3", v, 8'h01);
    chk("R2", "req_len", req_len, 8'h03);

    // R4 hand-over
    hw(2'd0, 8'h04);
    hr(2'd0, v); chk("R4", "attention set", v, 8'h04);
    chk("R4", "req_valid pulse", {7'd0, req_valid}, 8'h01);
    hr(2'd0, v); chk("R4", "busy after take", v, 8'h80);
    chk("R4", "req_valid one cycle", {7'd0, req_valid}, 8'h00);

    // R5 attention held while busy
    hw(2'd0, 8'h04);
    hr(2'd0, v); chk("R5", "pending while busy", v, 8'h84);
    hr(2'd0, v); chk("R5", "still pending", v, 8'h84);
    chk("R5", "no take while busy", {7'd0, req_valid}, 8'h00);
    pulse_done();
    hr(2'd0, v); chk("R5", "busy released", v, 8'h04);
    chk("R5", "pending taken", {7'd0, req_valid}, 8'h01);
    pulse_done();
    hr(2'd0, v); chk("R5", "idle again", v, 8'h00);

    // R6 / R9 response and interrupt
    rsp_load(3'd0, 8'h02); rsp_load(3'd1, 8'h1c); rsp_load(3'd2, 8'h05);
    hw(2'd2, 8'h01);
    pulse_post();
    chk("R9", "irq on attention rise", {7'd0, host_irq}, 8'h01);
    hr(2'd0, v); chk("R6", "b2h set", v, 8'h08);
    hr(2'd2, v); chk("R9", "irq reg pending", v, 8'h03);
    hw(2'd2, 8'h03);
    chk("R9", "irq after ack", {7'd0, host_irq}, 8'h00);
    hr(2'd2, v); chk("R9", "enable kept", v, 8'h01);
    pulse_post();
    hr(2'd2, v); chk("R9", "no pending without rise", v, 8'h01);
    chk("R9", "irq stays low", {7'd0, host_irq}, 8'h00);
    hw(2'd0, 8'h08);
    hr(2'd0, v); chk("R6", "b2h cleared", v, 8'h00);

    // R3 response reading with host busy toggled around it
    hw(2'd0, 8'h40);
    hr(2'd0, v); chk("R8", "host busy on", v, 8'h40);
    hw(2'd0, 8'h02);
    hr(2'd1, v); chk("R3", "rsp byte 0", v, 8'h02);
    hr(2'd1, v); chk("R3", "rsp byte 1", v, 8'h1c);
    hr(2'd1, v); chk("R3", "rsp byte 2", v, 8'h05);
    hw(2'd0, 8'h02);
    hr(2'd1, v); chk("R3", "rewind", v, 8'h02);
    hw(2'd0, 8'h40);
    hr(2'd0, v); chk("R8", "host busy off", v, 8'h00);

    // R7 event attention
    pulse_sms();
    hr(2'd0, v); chk("R7", "event set", v, 8'h10);
    hw(2'd0, 8'h10);
    hr(2'd0, v); chk("R7", "event cleared", v, 8'h00);

    // R10 write pointer wrap
    hw(2'd0, 8'h01);
    for (int i = 0; i < DEPTH + 1; i++) hw(2'd1, 8'hA0 + 8'(i));
    mrd(3'd0, v); chk("R10", "write wrap index 0", v, 8'hA8);
    mrd(3'd1, v); chk("R10", "write wrap index 1", v, 8'hA1);
    chk("R10", "req_len after wrap", req_len, 8'hA8);

    // R10 read pointer wrap
    for (int i = 0; i < DEPTH; i++) rsp_load(AW'(i), 8'h50 + 8'(i));
    hw(2'd0, 8'h02);
    for (int i = 0; i < DEPTH; i++) begin
      hr(2'd1, v);
      chk("R3", $sformatf("rsp index %0d", i), v, 8'h50 + 8'(i));
    end
    hr(2'd1, v); chk("R10", "read wrap", v, 8'h50);

    hr(2'd0, v); chk("R11", "ctrl idle at end", v, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule